// File: doc/BRIEF.md
# Transmit descriptor chain walker

This block walks a linked chain of transmit descriptors held in a 32-bit memory. Once software has loaded the current pointer and then writes a new tail pointer while the run control is high, the walker reads each descriptor. It hands a transfer command (buffer address, byte count, first-of-frame and last-of-frame marks) to a downstream data mover and then marks the descriptor done by writing its status word. It keeps walking until it has finished the descriptor that matches the tail pointer, or until it reaches a descriptor that software never recycled because its done flag is still set.

Descriptors sit on word-aligned byte addresses. Each 64-bit pointer field is reduced to its low 32-bit word. The walker keeps the byte position within the current frame. It latches the application words of the descriptor that opens a frame, and on the descriptor that closes a frame it emits a one-cycle frame pulse carrying the total frame length. An idle flag and a busy flag tell the surrounding register logic whether the chain has been drained.

Top module: `sg_walker`

## Requirements
- R1: After reset, idle_o is 1, busy_o is 0, cur_ptr_o is 0, and mem_req_o, cmd_valid_o and frame_done_o are 0.
- R2: A tail write (tail_wr_i) while run_i is 1 and the walker is not busy starts a walk at cur_ptr_o. The reads of each descriptor go in this order: byte offsets 0x00 (next pointer low word), 0x08 (buffer address low word), 0x18 (control), 0x1C (status), then 0x20, 0x24, ... 0x34 (six application words). A tail write while run_i is 0 clears idle_o but makes no memory access.
- R3: If status bit 31 of a fetched descriptor is already set, no command is issued and that descriptor is not written. idle_o becomes 1 and cur_ptr_o stays at that descriptor.
- R4: The command carries the buffer word as cmd_addr_o, control bits [22:0] as cmd_len_o, control bit 27 as cmd_sof_o and control bit 26 as cmd_eof_o. All of these stay stable while cmd_valid_o is 1 and cmd_ready_i is 0.
- R5: After the command is accepted, the walker writes (length | 0x8000_0000) to descriptor address + 0x1C.
- R6: After the write-back, cur_ptr_o takes the descriptor's next pointer. If the finished descriptor was the tail, the walk ends with idle_o 1 and busy_o 0; otherwise the next descriptor is fetched. idle_o is never 1 while busy_o is 1.
- R7: One cycle after a command with the last-of-frame mark is accepted, frame_done_o pulses for one cycle. frame_len_o then holds the sum of the lengths from the latest first-of-frame descriptor through that one.
- R8: app_o holds the six application words of the most recent first-of-frame descriptor, word k at bits [32k+31:32k]. Other descriptors leave it unchanged.
- R9: A memory request holds its address and direction until mem_gnt_i. A new request is made only after the previous read's data has returned.
- R10: cur_wr_i is ignored while busy_o is 1.
- R11: A tail write during a walk moves the stop point, so the walk continues up to the new tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run control; 1 allows a tail write to start a walk |
| cur_wr_i | input | 1 | Load current pointer (honoured only when not busy) |
| cur_ptr_i | input | 32 | New current pointer |
| tail_wr_i | input | 1 | Tail pointer update strobe |
| tail_ptr_i | input | 32 | New tail pointer |
| cur_ptr_o | output | 32 | Current descriptor pointer |
| idle_o | output | 1 | Chain drained flag |
| busy_o | output | 1 | Walker active |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| cmd_valid_o | output | 1 | Transfer command valid |
| cmd_ready_i | input | 1 | Data mover takes the command |
| cmd_addr_o | output | 32 | Buffer address |
| cmd_len_o | output | 23 | Byte count |
| cmd_sof_o | output | 1 | First descriptor of frame |
| cmd_eof_o | output | 1 | Last descriptor of frame |
| frame_done_o | output | 1 | Frame completion pulse |
| frame_len_o | output | 24 | Total length of the completed frame |
| app_o | output | 192 | Application words of the current frame |

## Verification
The hardest case to reach is a change to the stop condition while a walk is in flight. It needs a tail write that lands while several descriptors are still between the current pointer and the old tail. It also needs a current-pointer write that must be dropped because it arrives mid-walk. The bench times both strobes a few cycles after the start, while the first descriptor is still being fetched under a stalling memory, so they land deep inside the walk. Chain length, frame grouping, the position of a stale done flag, and the stall patterns of both the memory and the command sink are swept, so that every frame boundary meets both handshakes under back-pressure.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned APP_N    = 6;
  localparam int unsigned FIX_N    = 4;
  localparam int unsigned OFF_STAT = 28;
  localparam int unsigned CMPL_BIT = 31;
  localparam int unsigned SOF_BIT  = 27;
  localparam int unsigned EOF_BIT  = 26;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_ISSUE, S_WBACK, S_ADV
  } walk_st_e;

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} port_st_e;

  // fetch slot -> byte offset: next, buffer, control, status, app words
  function automatic logic [7:0] word_off(input logic [3:0] idx);
    case (idx)
      4'd0:    word_off = 8'd0;
      4'd1:    word_off = 8'd8;
      4'd2:    word_off = 8'd24;
      4'd3:    word_off = 8'd28;
      default: word_off = 8'd16 + {2'b00, idx, 2'b00};
    endcase
  endfunction
endpackage

// File: rtl/sgw_mem_port.sv
module sgw_mem_port
  import sgw_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  port_st_e      st_q;
  logic          we_q;
  logic [DW-1:0] addr_q, wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= P_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (st_q)
        P_IDLE: if (start_i) begin
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          st_q    <= P_REQ;
        end
        P_REQ:   if (mem_gnt_i) st_q <= we_q ? P_IDLE : P_WAIT;
        P_WAIT:  if (mem_rvalid_i) st_q <= P_IDLE;
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign idle_o      = (st_q == P_IDLE);
  assign done_o      = ((st_q == P_REQ) && mem_gnt_i && we_q) ||
                       ((st_q == P_WAIT) && mem_rvalid_i);
  assign rdata_o     = mem_rdata_i;
  assign mem_req_o   = (st_q == P_REQ);
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  // R9: request held until granted
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R9: no new request before read data returns
  a_r9_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i && !mem_we_o |=> !mem_req_o);
endmodule

// File: rtl/sgw_desc_capture.sv
module sgw_desc_capture
  import sgw_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 23,
  parameter int unsigned APP_W = APP_N,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    next_o,
  output logic [DW-1:0]    buf_o,
  output logic [LEN_W-1:0] len_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic             cmpl_o,
  output logic [APP_W*DW-1:0] app_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_o <= '0;
      buf_o  <= '0;
      len_o  <= '0;
      sof_o  <= 1'b0;
      eof_o  <= 1'b0;
      cmpl_o <= 1'b0;
    end else if (we_i) begin
      case (idx_i)
        IDX_W'(0): next_o <= data_i;
        IDX_W'(1): buf_o  <= data_i;
        IDX_W'(2): begin
          len_o <= data_i[LEN_W-1:0];
          sof_o <= data_i[SOF_BIT];
          eof_o <= data_i[EOF_BIT];
        end
        IDX_W'(3): cmpl_o <= data_i[CMPL_BIT];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < APP_W; g++) begin : g_app
    localparam int unsigned SLOT = FIX_N + g;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) app_o[g*DW +: DW] <= '0;
      else if (we_i && idx_i == IDX_W'(SLOT)) app_o[g*DW +: DW] <= data_i;
    end
  end
endmodule

// File: rtl/sgw_frame_track.sv
module sgw_frame_track #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 23,
  parameter int unsigned POS_W = 24,
  parameter int unsigned APP_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                open_i,
  input  logic [APP_W*DW-1:0] app_i,
  input  logic                add_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                last_i,
  output logic [APP_W*DW-1:0] app_o,
  output logic                done_o,
  output logic [POS_W-1:0]    len_o
);
  logic [POS_W-1:0] pos_q, pos_sum;

  assign pos_sum = pos_q + POS_W'(len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      app_o  <= '0;
      done_o <= 1'b0;
      len_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (open_i) begin
        pos_q <= '0;
        app_o <= app_i;
      end else if (add_i) begin
        if (last_i) begin
          len_o  <= pos_sum;
          done_o <= 1'b1;
          pos_q  <= '0;
        end else begin
          pos_q <= pos_sum;
        end
      end
    end
  end

  // R7: position restarts after each frame end
  a_r7_pos_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pos_q == '0);
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 23,
  parameter int unsigned POS_W = 24,
  parameter int unsigned APP_W = APP_N
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                cur_wr_i,
  input  logic [DW-1:0]       cur_ptr_i,
  input  logic                tail_wr_i,
  input  logic [DW-1:0]       tail_ptr_i,
  output logic [DW-1:0]       cur_ptr_o,
  output logic                idle_o,
  output logic                busy_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [DW-1:0]       mem_addr_o,
  output logic [DW-1:0]       mem_wdata_o,
  input  logic                mem_gnt_i,
  input  logic                mem_rvalid_i,
  input  logic [DW-1:0]       mem_rdata_i,
  output logic                cmd_valid_o,
  input  logic                cmd_ready_i,
  output logic [DW-1:0]       cmd_addr_o,
  output logic [LEN_W-1:0]    cmd_len_o,
  output logic                cmd_sof_o,
  output logic                cmd_eof_o,
  output logic                frame_done_o,
  output logic [POS_W-1:0]    frame_len_o,
  output logic [APP_W*DW-1:0] app_o
);
  localparam int unsigned FETCH_N = FIX_N + APP_W;
  localparam int unsigned IDX_W   = $clog2(FETCH_N);

  walk_st_e          st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DW-1:0]     cur_q, tail_q;
  logic              idle_q;

  logic              p_start, p_idle, p_done;
  logic [DW-1:0]     p_addr, p_wdata, p_rdata;
  logic [7:0]        off;
  logic [DW-1:0]     d_next, d_buf;
  logic [LEN_W-1:0]  d_len;
  logic              d_sof, d_eof, d_cmpl;
  logic [APP_W*DW-1:0] d_app;

  assign off     = (st_q == S_WBACK) ? 8'(OFF_STAT) : word_off(4'(idx_q));
  assign p_addr  = cur_q + {{(DW-8){1'b0}}, off};
  assign p_wdata = {{(DW-LEN_W){1'b0}}, d_len} | (DW'(1) << CMPL_BIT);
  assign p_start = ((st_q == S_FETCH) || (st_q == S_WBACK)) && p_idle;

  sgw_mem_port #(.DW(DW)) u_port (
    .clk_i, .rst_ni,
    .start_i(p_start), .we_i(st_q == S_WBACK), .addr_i(p_addr), .wdata_i(p_wdata),
    .idle_o(p_idle), .done_o(p_done), .rdata_o(p_rdata),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i
  );

  sgw_desc_capture #(.DW(DW), .LEN_W(LEN_W), .APP_W(APP_W), .IDX_W(IDX_W)) u_cap (
    .clk_i, .rst_ni,
    .we_i((st_q == S_FETCH) && p_done), .idx_i(idx_q), .data_i(p_rdata),
    .next_o(d_next), .buf_o(d_buf), .len_o(d_len), .sof_o(d_sof), .eof_o(d_eof),
    .cmpl_o(d_cmpl), .app_o(d_app)
  );

  sgw_frame_track #(.DW(DW), .LEN_W(LEN_W), .POS_W(POS_W), .APP_W(APP_W)) u_frame (
    .clk_i, .rst_ni,
    .open_i((st_q == S_CHECK) && !d_cmpl && d_sof), .app_i(d_app),
    .add_i((st_q == S_ISSUE) && cmd_ready_i), .len_i(d_len), .last_i(d_eof),
    .app_o, .done_o(frame_done_o), .len_o(frame_len_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      cur_q  <= '0;
      tail_q <= '0;
      idle_q <= 1'b1;
    end else begin
      if (tail_wr_i) begin
        tail_q <= tail_ptr_i;
        idle_q <= 1'b0;
      end
      case (st_q)
        S_IDLE: begin
          if (cur_wr_i) cur_q <= cur_ptr_i;
          if (tail_wr_i && run_i) begin
            idx_q <= '0;
            st_q  <= S_FETCH;
          end
        end
        S_FETCH: if (p_done) begin
          if (idx_q == IDX_W'(FETCH_N - 1)) st_q <= S_CHECK;
          else idx_q <= idx_q + 1'b1;
        end
        S_CHECK: begin
          if (d_cmpl) begin
            if (!tail_wr_i) idle_q <= 1'b1;
            st_q <= S_IDLE;
          end else begin
            st_q <= S_ISSUE;
          end
        end
        S_ISSUE: if (cmd_ready_i) st_q <= S_WBACK;
        S_WBACK: if (p_done) st_q <= S_ADV;
        S_ADV: begin
          cur_q <= d_next;
          idx_q <= '0;
          if (cur_q == tail_q && !tail_wr_i) begin
            idle_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            st_q <= S_FETCH;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cur_ptr_o   = cur_q;
  assign idle_o      = idle_q;
  assign busy_o      = (st_q != S_IDLE);
  assign cmd_valid_o = (st_q == S_ISSUE);
  assign cmd_addr_o  = d_buf;
  assign cmd_len_o   = d_len;
  assign cmd_sof_o   = d_sof;
  assign cmd_eof_o   = d_eof;

  // R1: nothing moves while not busy
  a_r1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !cmd_valid_o);
  // R2: a walk starts only from a tail write with run set
  a_r2_start_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(tail_wr_i && run_i));
  // R4: command stable under back-pressure
  a_r4_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) &&
      $stable(cmd_len_o) && $stable(cmd_sof_o) && $stable(cmd_eof_o));
  // R5: write-back carries the done flag and only the length bits
  a_r5_wb_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[CMPL_BIT] &&
      mem_wdata_o[CMPL_BIT-1:LEN_W] == '0);
  // R6: idle and busy exclusive
  a_r6_idle_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !busy_o);
  // R7: frame pulse follows an accepted last-of-frame command
  a_r7_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(cmd_valid_o && cmd_ready_i && cmd_eof_o));
  // R10: pointer moves only while walking or by an idle load
  a_r10_cur_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_ptr_o) |-> $past(busy_o) || $past(cur_wr_i));
endmodule

// File: tb/sg_walker_tb.sv
`timescale 1ns/1ps
module sg_walker_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic run = 0, cur_wr = 0, tail_wr = 0;
  logic [31:0] cur_ptr = 0, tail_ptr = 0;
  logic [31:0] cur_o, mem_addr, mem_wdata, cmd_addr;
  logic idle, busy, mem_req, mem_we, cmd_valid, cmd_sof, cmd_eof, fdone;
  logic mem_gnt, cmd_ready;
  logic mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;
  logic [22:0] cmd_len;
  logic [23:0] flen;
  logic [191:0] app;

  sg_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cur_wr_i(cur_wr), .cur_ptr_i(cur_ptr),
    .tail_wr_i(tail_wr), .tail_ptr_i(tail_ptr), .cur_ptr_o(cur_o), .idle_o(idle),
    .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_addr_o(cmd_addr), .cmd_len_o(cmd_len), .cmd_sof_o(cmd_sof), .cmd_eof_o(cmd_eof),
    .frame_done_o(fdone), .frame_len_o(flen), .app_o(app)
  );

  int cyc = 0, gnt_mod = 0, rdy_mod = 0;
  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:511];
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_gnt   = (gnt_mod == 0) || (cyc % gnt_mod) != 0;
  assign cmd_ready = (rdy_mod == 0) || (cyc % rdy_mod) != 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[10:2]];
      end
    end
  end

  int n_cmd = 0, n_fr = 0, n_rd = 0;
  logic [31:0] c_addr [0:31];
  int c_len [0:31];
  bit c_sof [0:31], c_eof [0:31];
  int f_len [0:31];
  logic [31:0] rd_addr [0:63];
  always @(posedge clk) if (rst_n) begin
    if (cmd_valid && cmd_ready && n_cmd < 32) begin
      c_addr[n_cmd] = cmd_addr; c_len[n_cmd] = int'(cmd_len);
      c_sof[n_cmd] = cmd_sof; c_eof[n_cmd] = cmd_eof; n_cmd++;
    end
    if (fdone && n_fr < 32) begin f_len[n_fr] = int'(flen); n_fr++; end
    if (mem_req && mem_gnt && !mem_we) begin
      if (n_rd < 64) rd_addr[n_rd] = mem_addr;
      n_rd++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] daddr(int i); return 32'h100 + 32'(i) * 32'h40; endfunction
  function automatic int elen(int i, int n); return 3 * i + n + 1; endfunction
  function automatic logic [31:0] ebuf(int i, int n); return 32'h1000_0000 + 32'(i * 256 + n); endfunction
  function automatic bit esof(int i, int g); return (i % g) == 0; endfunction
  function automatic bit eeof(int i, int n, int g); return ((i % g) == g - 1) || (i == n - 1); endfunction
  function automatic logic [31:0] eapp(int i, int n, int k); return 32'((n << 16) | (i << 8) | k); endfunction
  function automatic logic [31:0] eoff(int k);
    case (k) 0: return 0; 1: return 8; 2: return 24; 3: return 28; default: return 32'(16 + 4 * k); endcase
  endfunction

  task automatic build(int n, int g, int cpl);
    for (int i = 0; i < n; i++) begin
      int w = int'(daddr(i) >> 2);
      mem[w]     = daddr(i + 1);
      mem[w + 1] = 32'hdead_0000;
      mem[w + 2] = ebuf(i, n);
      mem[w + 3] = 32'hdead_0001;
      mem[w + 6] = 32'(elen(i, n)) | (32'(esof(i, g)) << 27) | (32'(eeof(i, n, g)) << 26);
      mem[w + 7] = (i == cpl) ? 32'h8000_0000 : 32'h0;
      for (int k = 0; k < 6; k++) mem[w + 8 + k] = eapp(i, n, k);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    n_cmd = 0; n_fr = 0; n_rd = 0;
  endtask

  task automatic load_cur(logic [31:0] v);
    @(negedge clk); cur_wr = 1; cur_ptr = v;
    @(negedge clk); cur_wr = 0;
  endtask

  task automatic write_tail(logic [31:0] v, bit r);
    @(negedge clk); tail_wr = 1; tail_ptr = v; run = r;
    @(negedge clk); tail_wr = 0;
  endtask

  task automatic wait_done();
    int cnt = 0;
    while (busy && cnt < 20000) begin @(negedge clk); cnt++; end
    if (busy) chk(0, "watchdog", 1, 0);
  endtask

  // compare one finished walk over descriptors 0..n-1 (cpl = first stale one)
  task automatic verify(int n, int g, int cpl);
    int ex = (cpl < n) ? cpl : n;
    int pos = 0, nf = 0, last_sof = -1;
    int ef [0:31];
    chk(n_cmd == ex, (cpl < n) ? "R3 cmd count" : "R6 cmd count", n_cmd, ex);
    for (int i = 0; i < ex && i < n_cmd; i++) begin
      chk(c_addr[i] == ebuf(i, n), "R4 addr", c_addr[i], ebuf(i, n));
      chk(c_len[i] == elen(i, n), "R4 len", c_len[i], elen(i, n));
      chk(c_sof[i] == esof(i, g) && c_eof[i] == eeof(i, n, g), "R4 marks",
          {c_sof[i], c_eof[i]}, {esof(i, g), eeof(i, n, g)});
      chk(mem[(daddr(i) >> 2) + 7] == (32'(elen(i, n)) | 32'h8000_0000), "R5 status",
          mem[(daddr(i) >> 2) + 7], 32'(elen(i, n)) | 32'h8000_0000);
      if (esof(i, g)) begin pos = 0; last_sof = i; end
      pos += elen(i, n);
      if (eeof(i, n, g)) begin ef[nf] = pos; nf++; pos = 0; end
    end
    if (cpl < n) begin
      chk(mem[(daddr(cpl) >> 2) + 7] == 32'h8000_0000, "R3 no write", mem[(daddr(cpl) >> 2) + 7], 32'h8000_0000);
      chk(cur_o == daddr(cpl), "R3 ptr", cur_o, daddr(cpl));
    end else chk(cur_o == daddr(n), "R6 ptr", cur_o, daddr(n));
    chk(idle == 1 && busy == 0, "R6 idle", {idle, busy}, 2'b10);
    chk(n_fr == nf, "R7 frames", n_fr, nf);
    for (int f = 0; f < nf && f < n_fr; f++) chk(f_len[f] == ef[f], "R7 length", f_len[f], ef[f]);
    if (last_sof >= 0)
      for (int k = 0; k < 6; k++)
        chk(app[k*32 +: 32] == eapp(last_sof, n, k), "R8 app", app[k*32 +: 32], eapp(last_sof, n, k));
    if (n_rd >= 10)
      for (int k = 0; k < 10; k++)
        chk(rd_addr[k] == daddr(0) + eoff(k), "R2 read order", rd_addr[k], daddr(0) + eoff(k));
    else chk(0, "R2 read count", n_rd, 10);
  endtask

  task automatic walk(int n, int g, int cpl, int gm, int rm);
    build(n, g, cpl);
    gnt_mod = gm; rdy_mod = rm;
    clear_logs();
    load_cur(daddr(0));
    write_tail(daddr(n - 1), 1);
    wait_done();
    verify(n, g, cpl);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog global", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(idle == 1 && busy == 0 && cur_o == 0, "R1 flags", {idle, busy, cur_o}, {2'b10, 32'h0});
    chk(!mem_req && !cmd_valid && !fdone, "R1 outputs", {mem_req, cmd_valid, fdone}, 3'b000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 tail write with run low: idle cleared, no access
    clear_logs();
    write_tail(daddr(0), 0);
    repeat (20) @(negedge clk);
    chk(busy == 0 && n_rd == 0, "R2 run low no walk", {busy, 32'(n_rd)}, 0);
    chk(idle == 0, "R2 run low idle clear", idle, 0);

    // sweep: length, grouping, stall patterns (R2 R4 R5 R6 R7 R8 R9)
    for (int n = 1; n <= 6; n++)
      for (int g = 1; g <= 3; g++)
        for (int s = 0; s < 4; s++)
          walk(n, g, 99, (s & 1) ? 3 : 0, (s & 2) ? 2 : 0);

    // R3 stale done flag at each position
    for (int c = 0; c < 5; c++) walk(5, 2, c, 3, 2);

    // R10 pointer load while busy is dropped
    build(4, 2, 99); gnt_mod = 3; rdy_mod = 0;
    clear_logs();
    load_cur(daddr(0));
    write_tail(daddr(3), 1);
    repeat (3) @(negedge clk);
    load_cur(32'h3c0);
    wait_done();
    chk(cur_o == daddr(4), "R10 ptr ignored", cur_o, daddr(4));
    chk(n_cmd == 4, "R10 cmd count", n_cmd, 4);

    // R11 tail moved during walk
    build(6, 3, 99); gnt_mod = 3; rdy_mod = 2;
    clear_logs();
    load_cur(daddr(0));
    write_tail(daddr(2), 1);
    repeat (4) @(negedge clk);
    write_tail(daddr(5), 1);
    wait_done();
    chk(n_cmd == 6, "R11 cmd count", n_cmd, 6);
    chk(cur_o == daddr(6), "R11 ptr", cur_o, daddr(6));
    chk(n_fr == 2, "R11 frames", n_fr, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule